// File: doc/BRIEF.md
# Staircase Harmonic-Elimination Gate Sequencer

This block drives the seven gate signals of a single-phase inverter. The inverter stacks three switched DC source cells in series and feeds a four-switch polarity bridge. A phase counter covers one output cycle in `4*QUARTER` ticks. Each tick, the counter position is compared with seven switching angles, which sets a signed staircase level. The level is then decoded into cell enables and a bridge pair. The angles are calculated offline to cancel low-order harmonics. They are held in a small computed table, and a modulation-index select picks one set of seven.

A level-mode select sets how the source cells are weighted:
- 1:2:4 gives 15 levels.
- 1:1:1 gives 7 levels.
- 1:2:2 gives 11 levels.

The angle set and the mode are taken only at the start of each output cycle. When the bridge changes from one switch pair to another, all four bridge gates are held off for a programmable dead time. The zero level is made by shorting the load through the two high-side switches or the two low-side switches, and the block uses the two pairs in turn. All pins are plain control and status pins. No data stream crosses the block's edge, so it has no valid/ready handshake.

Top module: `stair_seq`

## Requirements
- R1: During reset, and from the third clock after `en` falls, `gate_o` is all zero and `level_o` is 0. On the first clock edge with `en` high, the phase restarts at 0 and the configuration is latched. The outputs for phase p appear two clocks after that phase is reached.
- R2: Angle i (0..6) of set m is `(2i+1)*QUARTER/16 - m*QUARTER/(16*NUM_MI)` ticks. For QUARTER=64 and NUM_MI=4 this is `4+8i-m`.
  - In the first quarter of the cycle, the count c is the number of angles less than or equal to the quarter offset.
  - The second quarter uses offset `QUARTER-1-t`, which mirrors the first quarter.
  - Phases from `2*QUARTER` onward repeat the first half with a negative sign.
- R3: With `mode_sel`=0 (binary, 1:2:4 cells), the magnitude is c. `gate_o[2:0]` equals bits 2..0 of the magnitude. A positive level drives bits 3 and 4. A negative level drives bits 5 and 6.
- R4: At level 0 the cell gates `gate_o[2:0]` are all off. The bridge is either bits 3 and 5 (both high-side switches) or bits 4 and 6 (both low-side switches).
- R5: With `mode_sel`=1 (1:1:1 cells), the magnitude is c/2 rounded down. The cell gates are 001, 011 and 111 for magnitudes 1, 2 and 3.
- R6: With `mode_sel`=2 (1:2:2 cells), the magnitude is min(c,5). The cell gates are 001, 010, 011, 110 and 111 for magnitudes 1 to 5.
- R7: A change of `mi_sel` or `mode_sel` during a cycle has no effect until the next cycle starts.
- R8: When the bridge pair must change, all four bridge gates go off for exactly DEAD clocks before the new pair turns on. If the pair does not change, the bridge keeps its state.
- R9: Zero intervals alternate between the two zero pairs. The first zero interval after enabling uses the high-side pair (bits 3 and 5).
- R10: Bits 3 and 6 (left leg) are never on together, and bits 4 and 5 (right leg) are never on together.
- R11: While the sequencer runs, the level moves by at most one step per clock.
- R12: `mode_sel`=3 behaves exactly like the binary mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of the phase counter per cycle |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; when low, the phase is held at zero and the gates are off |
| mi_sel | input | $clog2(NUM_MI) | Modulation-index select, which chooses the angle set |
| mode_sel | input | 2 | Cell weighting: 0 binary, 1 equal, 2 one-two-two, 3 binary |
| gate_o | output | 7 | Gates: [2:0] cells, [3] left-high, [4] right-low, [5] right-high, [6] left-low |
| level_o | output | 4 | Signed staircase level, aligned with gate_o |

## Verification
The assertions check on every cycle the properties that must hold at all times:
- no leg is ever shorted;
- two bridge pairs never follow each other without an off gap;
- the bridge polarity agrees with the sign of the level;
- the cells are off at zero;
- the level magnitude stays within the mode's range and moves at most one step per clock.

Some behaviours can only be shown by the bench's scenarios:
- the exact staircase values at chosen phases for each mode and angle set;
- the exact length of the dead time;
- the order in which the two zero pairs alternate;
- a configuration change made mid-cycle being held back to the next cycle.

// File: rtl/stair_pkg.sv
package stair_pkg;
  localparam int NUM_ANG = 7;
  localparam int LVL_W   = 4;

  // Bridge pair encodings {left-low, right-high, right-low, left-high}
  localparam logic [3:0] BR_OFF = 4'b0000;
  localparam logic [3:0] BR_POS = 4'b0011;
  localparam logic [3:0] BR_NEG = 4'b1100;
  localparam logic [3:0] BR_ZHI = 4'b0101;
  localparam logic [3:0] BR_ZLO = 4'b1010;

  localparam logic [1:0] MODE_EQ  = 2'd1;
  localparam logic [1:0] MODE_122 = 2'd2;

  // Magnitude from count of passed angles
  function automatic logic [2:0] mag_of(logic [2:0] cnt, logic [1:0] mode);
    case (mode)
      MODE_EQ:  return cnt >> 1;
      MODE_122: return (cnt > 3'd5) ? 3'd5 : cnt;
      default:  return cnt;
    endcase
  endfunction

  // Source-cell enables for a magnitude
  function automatic logic [2:0] cells_of(logic [2:0] mag, logic [1:0] mode);
    case (mode)
      MODE_EQ: begin
        case (mag)
          3'd0:    return 3'b000;
          3'd1:    return 3'b001;
          3'd2:    return 3'b011;
          default: return 3'b111;
        endcase
      end
      MODE_122: begin
        case (mag)
          3'd0:    return 3'b000;
          3'd1:    return 3'b001;
          3'd2:    return 3'b010;
          3'd3:    return 3'b011;
          3'd4:    return 3'b110;
          default: return 3'b111;
        endcase
      end
      default: return mag;
    endcase
  endfunction

  function automatic logic [2:0] lvl_max(logic [1:0] mode);
    case (mode)
      MODE_EQ:  return 3'd3;
      MODE_122: return 3'd5;
      default:  return 3'd7;
    endcase
  endfunction

  function automatic logic [2:0] abs3(logic signed [LVL_W-1:0] l);
    logic signed [LVL_W-1:0] t;
    t = l[LVL_W-1] ? -l : l;
    return t[2:0];
  endfunction
endpackage

// File: rtl/stair_angle_rom.sv
module stair_angle_rom #(
  parameter int QUARTER = 64,
  parameter int NUM_MI  = 4,
  localparam int QW     = $clog2(QUARTER),
  localparam int MI_W   = $clog2(NUM_MI)
) (
  input  logic [MI_W-1:0]                        mi_i,
  output logic [stair_pkg::NUM_ANG-1:0][QW-1:0]  ang_o
);
  import stair_pkg::*;

  // Angle in ticks; ascending by construction, smallest >= 1 when QUARTER >= 16*NUM_MI
  function automatic logic [QW-1:0] ang_at(int m, int i);
    int v;
    int mm;
    mm = (m >= NUM_MI) ? NUM_MI - 1 : m;
    v  = ((2 * i + 1) * QUARTER) / 16 - (mm * QUARTER) / (16 * NUM_MI);
    return v[QW-1:0];
  endfunction

  for (genvar gi = 0; gi < NUM_ANG; gi++) begin : g_ang
    assign ang_o[gi] = ang_at(int'(mi_i), gi);
  end
endmodule

// File: rtl/stair_phase.sv
module stair_phase #(
  parameter int QUARTER = 64,
  parameter int NUM_MI  = 4,
  localparam int QW      = $clog2(QUARTER),
  localparam int MI_W    = $clog2(NUM_MI),
  localparam int PHASE_W = QW + 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   en,
  input  logic [MI_W-1:0]                        mi_i,
  input  logic [1:0]                             mode_i,
  input  logic [stair_pkg::NUM_ANG-1:0][QW-1:0]  ang_i,
  output logic [MI_W-1:0]                        mi_cfg_o,
  output logic                                   act_o,
  output logic [1:0]                             mode_o,
  output logic signed [stair_pkg::LVL_W-1:0]     level_o
);
  import stair_pkg::*;

  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(4 * QUARTER - 1);

  logic                     run_q;
  logic [PHASE_W-1:0]       phase_q;
  logic [MI_W-1:0]          mi_q;
  logic [1:0]               mode_q;
  logic [1:0]               mode_lvl_q;
  logic                     act_q;
  logic signed [LVL_W-1:0]  level_q;

  logic [1:0]               quarter;
  logic [QW-1:0]            pos;
  logic [2:0]               cnt;
  logic [2:0]               mag;
  logic signed [LVL_W-1:0]  level_d;

  assign quarter = phase_q[PHASE_W-1 -: 2];
  assign pos     = quarter[0] ? ~phase_q[QW-1:0] : phase_q[QW-1:0];

  always_comb begin
    cnt = 3'd0;
    for (int i = 0; i < NUM_ANG; i++) begin
      if (ang_i[i] <= pos) cnt = cnt + 3'd1;
    end
  end

  assign mag     = mag_of(cnt, mode_q);
  assign level_d = quarter[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      phase_q    <= '0;
      mi_q       <= '0;
      mode_q     <= '0;
      mode_lvl_q <= '0;
      act_q      <= 1'b0;
      level_q    <= '0;
    end else begin
      act_q      <= run_q;
      level_q    <= run_q ? level_d : '0;
      mode_lvl_q <= mode_q;
      if (!en) begin
        run_q   <= 1'b0;
        phase_q <= '0;
      end else if (!run_q || phase_q == LAST) begin
        run_q   <= 1'b1;
        phase_q <= '0;
        mi_q    <= mi_i;
        mode_q  <= mode_i;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign mi_cfg_o = mi_q;
  assign act_o    = act_q;
  assign mode_o   = mode_lvl_q;
  assign level_o  = level_q;

  // R11
  level_step_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && $past(act_q)) |->
      ((int'(level_q) - int'($past(level_q)) <= 1) &&
       (int'(level_q) - int'($past(level_q)) >= -1)));

  // R5
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (abs3(level_q) <= lvl_max(mode_lvl_q)));
endmodule

// File: rtl/stair_bridge.sv
module stair_bridge #(
  parameter int DEAD  = 2,
  localparam int DT_W = $clog2(DEAD + 1)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               act_i,
  input  logic [1:0]                         mode_i,
  input  logic signed [stair_pkg::LVL_W-1:0] level_i,
  output logic [6:0]                         gate_o,
  output logic signed [stair_pkg::LVL_W-1:0] level_o
);
  import stair_pkg::*;

  logic [3:0]              br_q;
  logic [DT_W-1:0]         dt_q;
  logic [2:0]              cells_q;
  logic signed [LVL_W-1:0] lvl_q;
  logic                    zsel_q;
  logic                    zprev_q;

  logic                    is_zero;
  logic                    enter_zero;
  logic                    zsel_eff;
  logic [3:0]              target;

  assign is_zero    = (level_i == '0);
  assign enter_zero = act_i && is_zero && !zprev_q;
  assign zsel_eff   = zsel_q ^ enter_zero;

  always_comb begin
    if (!act_i)                target = BR_OFF;
    else if (is_zero)          target = zsel_eff ? BR_ZLO : BR_ZHI;
    else if (level_i[LVL_W-1]) target = BR_NEG;
    else                       target = BR_POS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      br_q    <= BR_OFF;
      dt_q    <= '0;
      cells_q <= '0;
      lvl_q   <= '0;
      zsel_q  <= 1'b0;
      zprev_q <= 1'b1;
    end else begin
      cells_q <= act_i ? cells_of(abs3(level_i), mode_i) : 3'b000;
      lvl_q   <= level_i;
      zsel_q  <= act_i ? zsel_eff : 1'b0;
      zprev_q <= !act_i || is_zero;
      if (dt_q != '0) begin
        dt_q <= dt_q - 1'b1;
        if (dt_q == DT_W'(1)) br_q <= target;
      end else if (br_q != target) begin
        if (br_q == BR_OFF) begin
          br_q <= target;
        end else begin
          br_q <= BR_OFF;
          dt_q <= DT_W'(DEAD);
        end
      end
    end
  end

  assign gate_o  = {br_q, cells_q};
  assign level_o = lvl_q;

  // R10
  leg_left_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_o[3] && gate_o[6]));
  // R10
  leg_right_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_o[4] && gate_o[5]));
  // R8
  dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (br_q != BR_OFF) |=> ((br_q == BR_OFF) || $stable(br_q)));
  // R3
  pos_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (br_q == BR_POS) |-> (lvl_q > 0));
  // R3
  neg_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (br_q == BR_NEG) |-> (lvl_q < 0));
  // R4
  zero_pair_chk: assert property (@(posedge clk) disable iff (rst)
    ((br_q == BR_ZHI) || (br_q == BR_ZLO)) |-> (lvl_q == 0));
  // R4
  zero_cells_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_q == 0) |-> (cells_q == 3'b000));
endmodule

// File: rtl/stair_seq.sv
module stair_seq #(
  parameter int QUARTER = 64,
  parameter int NUM_MI  = 4,
  parameter int DEAD    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic [$clog2(NUM_MI)-1:0]   mi_sel,
  input  logic [1:0]                  mode_sel,
  output logic [6:0]                  gate_o,
  output logic signed [3:0]           level_o
);
  import stair_pkg::*;

  localparam int QW   = $clog2(QUARTER);
  localparam int MI_W = $clog2(NUM_MI);

  logic [NUM_ANG-1:0][QW-1:0] ang;
  logic [MI_W-1:0]            mi_cfg;
  logic                       act;
  logic [1:0]                 mode_lvl;
  logic signed [LVL_W-1:0]    level_raw;

  stair_angle_rom #(.QUARTER(QUARTER), .NUM_MI(NUM_MI)) u_rom (
    .mi_i  (mi_cfg),
    .ang_o (ang)
  );

  stair_phase #(.QUARTER(QUARTER), .NUM_MI(NUM_MI)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .mi_i     (mi_sel),
    .mode_i   (mode_sel),
    .ang_i    (ang),
    .mi_cfg_o (mi_cfg),
    .act_o    (act),
    .mode_o   (mode_lvl),
    .level_o  (level_raw)
  );

  stair_bridge #(.DEAD(DEAD)) u_bridge (
    .clk     (clk),
    .rst     (rst),
    .act_i   (act),
    .mode_i  (mode_lvl),
    .level_i (level_raw),
    .gate_o  (gate_o),
    .level_o (level_o)
  );
endmodule

// File: tb/stair_seq_tb.sv
module stair_seq_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst;
  logic              en;
  logic [1:0]        mi;
  logic [1:0]        mode;
  logic [6:0]        gate;
  logic signed [3:0] lvl;

  int checks = 0;
  int errors = 0;
  int cur    = 0;

  stair_seq #(.QUARTER(64), .NUM_MI(4), .DEAD(2)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .mi_sel   (mi),
    .mode_sel (mode),
    .gate_o   (gate),
    .level_o  (lvl)
  );

  // {mode, mi, phase, expected level}
  localparam logic [17:0] VECS [14] = '{
    {2'd0, 2'd0, 10'd30,  4'h4},   // R2 R3
    {2'd0, 2'd0, 10'd63,  4'h7},   // R2 R3
    {2'd0, 2'd0, 10'd100, 4'h3},   // R2 mirror
    {2'd0, 2'd0, 10'd140, 4'hE},   // R2 negative half
    {2'd0, 2'd0, 10'd250, 4'hF},   // R2
    {2'd0, 2'd2, 10'd40,  4'h5},   // R2 angle set 2
    {2'd0, 2'd3, 10'd200, 4'h9},   // R2 angle set 3
    {2'd1, 2'd0, 10'd30,  4'h2},   // R5
    {2'd1, 2'd0, 10'd63,  4'h3},   // R5
    {2'd1, 2'd0, 10'd150, 4'hF},   // R5
    {2'd2, 2'd0, 10'd63,  4'h5},   // R6
    {2'd2, 2'd0, 10'd100, 4'h3},   // R6
    {2'd2, 2'd1, 10'd220, 4'hB},   // R6
    {2'd3, 2'd0, 10'd45,  4'h6}    // R12
  };

  function automatic logic [6:0] exp_gate(logic [1:0] md, logic signed [3:0] l);
    logic [2:0] m;
    logic [2:0] c;
    m = (l < 0) ? 3'(-l) : 3'(l);
    if (md == 2'd1)
      c = (m == 0) ? 3'b000 : (m == 1) ? 3'b001 : (m == 2) ? 3'b011 : 3'b111;
    else if (md == 2'd2)
      c = (m == 0) ? 3'b000 : (m == 1) ? 3'b001 : (m == 2) ? 3'b010 :
          (m == 3) ? 3'b011 : (m == 4) ? 3'b110 : 3'b111;
    else
      c = m;
    if (l > 0)      return {4'b0011, c};
    else if (l < 0) return {4'b1100, c};
    else            return {4'b0000, c};
  endfunction

  task automatic chk_gate(string req, logic [6:0] exp);
    checks++;
    if (gate !== exp) begin
      errors++;
      $display("FAIL %s gate actual=%b expected=%b", req, gate, exp);
    end
  endtask

  task automatic chk_lvl(string req, logic signed [3:0] exp);
    checks++;
    if (lvl !== exp) begin
      errors++;
      $display("FAIL %s level actual=%0d expected=%0d", req, lvl, exp);
    end
  endtask

  task automatic start_run(logic [1:0] md, logic [1:0] m);
    @(negedge clk);
    en = 1'b0;
    repeat (8) @(negedge clk);
    mode = md;
    mi   = m;
    en   = 1'b1;
    @(posedge clk);
    cur = 0;
  endtask

  task automatic sample_at(int p);
    repeat (p + 2 - cur) @(posedge clk);
    cur = p + 2;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst  = 1'b1;
    en   = 1'b1;
    mi   = 2'd0;
    mode = 2'd0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk_gate("R1 reset", 7'b0000000);
    chk_lvl("R1 reset", 4'sd0);
    en = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // vector table walk
    for (int k = 0; k < 14; k++) begin
      start_run(VECS[k][17:16], VECS[k][15:14]);
      sample_at(int'(VECS[k][13:4]));
      chk_lvl($sformatf("R2 vec%0d", k), $signed(VECS[k][3:0]));
      chk_gate($sformatf("R3 vec%0d", k), exp_gate(VECS[k][17:16], $signed(VECS[k][3:0])));
    end

    // R4 R9 first zero uses high-side pair; R8 dead time
    start_run(2'd0, 2'd0);
    sample_at(2);
    chk_gate("R9 first zero high pair", 7'b0101000);
    chk_lvl("R4 zero level", 4'sd0);
    sample_at(4);
    chk_gate("R8 dead start", 7'b0000001);
    sample_at(5);
    chk_gate("R8 dead hold", 7'b0000001);
    sample_at(6);
    chk_gate("R8 pair after dead", 7'b0011001);
    sample_at(125);
    chk_gate("R8 dead at zero entry", 7'b0000000);
    sample_at(128);
    chk_gate("R9 second zero low pair", 7'b1010000);
    chk_lvl("R4 zero mid", 4'sd0);
    sample_at(257);
    chk_gate("R9 third zero high pair", 7'b0101000);

    // R7 mid-cycle config change
    start_run(2'd0, 2'd0);
    sample_at(10);
    mi   = 2'd3;
    mode = 2'd1;
    sample_at(100);
    chk_lvl("R7 held config", 4'sd3);
    chk_gate("R7 held config", exp_gate(2'd0, 4'sd3));
    sample_at(356);
    chk_lvl("R7 new config next cycle", 4'sd2);
    chk_gate("R7 new config next cycle", exp_gate(2'd1, 4'sd2));

    // R1 disable
    en = 1'b0;
    repeat (5) @(negedge clk);
    chk_gate("R1 disabled", 7'b0000000);
    chk_lvl("R1 disabled", 4'sd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule